// File: doc/BRIEF.md
# Tile Delta Colour Compressor

This block takes one 8x8 tile of render-target samples, streamed in raster order one sample per cycle, and turns it into a 2-bit tile code plus a packed payload. The first sample of the tile is the estimate for every other sample. Each later sample is stored only as its signed distance from that first sample. After the tile is complete, the block picks the narrowest delta field out of 2, 3 and 4 bits that holds every distance in the tile. If no field is wide enough, it keeps the tile unpacked.

Float render targets use the same integer datapath. Each incoming bit pattern is first mapped to an integer code whose order follows the numeric order, so nearby values get nearby codes. The block also has a combinational expand path, which rebuilds a full tile from a code and a payload. It is used to check round trips and needs no knowledge of the format beyond the final inverse mapping.

Top module: `tdc_tile_compress`

## Requirements
- R1: `inReady` is high while a tile is being filled and low for every cycle that `outValid` is high. The first payload word appears in the cycle right after the 64th sample is accepted. After the word flagged `outLast`, the next cycle has `outValid` low and `inReady` high.
- R2: When `inFloat` is 1, a sample with bit 7 set is replaced by its bitwise inverse. A sample with bit 7 clear has only bit 7 inverted. When `inFloat` is 0, the sample is used unchanged. All later steps work on this mapped code.
- R3: The delta of sample i is (mapped sample i − mapped sample 0) modulo 256, read as a two's complement number.
- R4: `outCode` is 2'b11 when every delta lies in −2..1. Otherwise it is 2'b10 when every delta lies in −4..3. Otherwise it is 2'b01 when every delta lies in −8..7.
- R5: When some delta lies outside −8..7, `outCode` is 2'b00. The payload is then the 64 mapped samples in raster order, one per word.
- R6: In the packed modes, payload bits [7:0] hold mapped sample 0. The low bits of the delta of sample i (i = 1..63) sit at bit offset 8 + (i−1)·width. Words leave least significant first, word k carrying payload bits [8k+7:8k]. Bits beyond the last delta are zero.
- R7: A tile is emitted in 17, 25, 33 or 64 consecutive words for codes 11, 10, 01 and 00 respectively. `outLast` is high on the final word only.
- R8: Given `expCode` and `expPayload` in the R5/R6 layout, and `expFloat` set the same as `inFloat` was, `expTile` holds the original 64 input samples, sample i at bits [8i+7:8i].
- R9: After reset, `inReady` is 1 and `outValid` is 0. A partly filled tile is discarded.
- R10: A cycle in which `inValid` is low, or in which `inValid` is high while `inReady` is low, takes no sample and leaves the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample present |
| inReady | output | 1 | Block accepts a sample this cycle |
| inData | input | 8 | Sample bit pattern |
| inFloat | input | 1 | Sample is a float pattern, to be order-mapped |
| outValid | output | 1 | Payload word present |
| outLast | output | 1 | Final word of the tile |
| outCode | output | 2 | Tile code, valid while outValid |
| outWord | output | 8 | Payload word |
| expCode | input | 2 | Code of the tile to expand |
| expFloat | input | 1 | Apply the inverse float mapping after expansion |
| expPayload | input | 512 | Payload to expand |
| expTile | output | 512 | Expanded tile |

## Verification
A fit flag that clears too late or too early shows up as a wrong `outCode` and a wrong word count, on the first word of the burst following the 64th sample. A stale or misaddressed buffer entry changes one payload word inside that same burst, and then breaks the round trip through the expand path. A word counter or fill counter that slips moves `outLast`, or moves the start of the burst, by a cycle. The cycle-exact checks on `inReady`, `outValid` and `outLast` catch this right away.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    CODE_RAW = 2'b00,
    CODE_D4  = 2'b01,
    CODE_D3  = 2'b10,
    CODE_D2  = 2'b11
  } tileCode_t;

  typedef struct packed {
    logic capture;
    logic firstBeat;
  } dpStrobe_t;
endpackage

// File: rtl/tdc_datapath.sv
module tdc_datapath
  import tdc_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int TILE_N = 64,
  localparam int IDX_W = $clog2(TILE_N),
  localparam int PAY_W = SAMPLE_W * TILE_N
) (
  input  logic                clk,
  input  logic                rst,
  input  dpStrobe_t           strobe,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [IDX_W-1:0]    wordIdx,
  input  logic [SAMPLE_W-1:0] inData,
  input  logic                inFloat,
  output tileCode_t           code,
  output logic [IDX_W-1:0]    lastWord,
  output logic [SAMPLE_W-1:0] outWord
);
  localparam logic [SAMPLE_W-1:0] MSB = SAMPLE_W'(1) << (SAMPLE_W - 1);
  localparam int WORDS_D2 = (2 * SAMPLE_W - 1 + (TILE_N - 1) * 2) / SAMPLE_W;
  localparam int WORDS_D3 = (2 * SAMPLE_W - 1 + (TILE_N - 1) * 3) / SAMPLE_W;
  localparam int WORDS_D4 = (2 * SAMPLE_W - 1 + (TILE_N - 1) * 4) / SAMPLE_W;

  logic [SAMPLE_W-1:0] tileMem [TILE_N];
  logic [SAMPLE_W-1:0] mapped, delta;
  logic fit2, fit3, fit4;
  logic [PAY_W-1:0] pk2, pk3, pk4, pkRaw, sel;

  function automatic logic fitsIn(input logic [SAMPLE_W-1:0] d, input int k);
    int v;
    v = int'($signed(d));
    return (v >= -(1 << (k - 1))) && (v <= (1 << (k - 1)) - 1);
  endfunction

  always_comb begin
    if (!inFloat) mapped = inData;
    else if (inData[SAMPLE_W-1]) mapped = ~inData;
    else mapped = inData ^ MSB;
    delta = mapped - tileMem[0];
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) tileMem[wrIdx] <= mapped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fit2 <= 1'b1;
      fit3 <= 1'b1;
      fit4 <= 1'b1;
    end else if (strobe.capture) begin
      if (strobe.firstBeat) begin
        fit2 <= 1'b1;
        fit3 <= 1'b1;
        fit4 <= 1'b1;
      end else begin
        fit2 <= fit2 & fitsIn(delta, 2);
        fit3 <= fit3 & fitsIn(delta, 3);
        fit4 <= fit4 & fitsIn(delta, 4);
      end
    end
  end

  always_comb begin
    pk2 = '0;
    pk3 = '0;
    pk4 = '0;
    pkRaw = '0;
    pk2[SAMPLE_W-1:0] = tileMem[0];
    pk3[SAMPLE_W-1:0] = tileMem[0];
    pk4[SAMPLE_W-1:0] = tileMem[0];
    for (int i = 1; i < TILE_N; i++) begin
      logic [SAMPLE_W-1:0] diff;
      diff = tileMem[i] - tileMem[0];
      pk2[SAMPLE_W + (i - 1) * 2 +: 2] = diff[1:0];
      pk3[SAMPLE_W + (i - 1) * 3 +: 3] = diff[2:0];
      pk4[SAMPLE_W + (i - 1) * 4 +: 4] = diff[3:0];
    end
    for (int i = 0; i < TILE_N; i++) pkRaw[i * SAMPLE_W +: SAMPLE_W] = tileMem[i];
  end

  always_comb begin
    if (fit2) begin
      code = CODE_D2; sel = pk2; lastWord = IDX_W'(WORDS_D2 - 1);
    end else if (fit3) begin
      code = CODE_D3; sel = pk3; lastWord = IDX_W'(WORDS_D3 - 1);
    end else if (fit4) begin
      code = CODE_D4; sel = pk4; lastWord = IDX_W'(WORDS_D4 - 1);
    end else begin
      code = CODE_RAW; sel = pkRaw; lastWord = IDX_W'(TILE_N - 1);
    end
    outWord = sel[int'(wordIdx) * SAMPLE_W +: SAMPLE_W];
  end

  // R4
  fit_nesting_chk: assert property (@(posedge clk) disable iff (rst)
    (!fit2 || fit3) && (!fit3 || fit4));
endmodule

// File: rtl/tdc_control.sv
module tdc_control
  import tdc_pkg::*;
#(
  parameter int TILE_N = 64,
  localparam int IDX_W = $clog2(TILE_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IDX_W-1:0] lastWord,
  output logic             inReady,
  output logic             outValid,
  output logic             outLast,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] wordIdx
);
  typedef enum logic {ST_FILL, ST_SEND} state_t;
  state_t state;
  logic [IDX_W-1:0] fillCnt;
  logic accept;

  assign inReady = (state == ST_FILL);
  assign accept = inValid && inReady;
  assign outValid = (state == ST_SEND);
  assign outLast = outValid && (wordIdx == lastWord);
  assign wrIdx = fillCnt;
  assign strobe.capture = accept;
  assign strobe.firstBeat = (fillCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FILL;
      fillCnt <= '0;
      wordIdx <= '0;
    end else if (state == ST_FILL) begin
      if (accept) begin
        if (fillCnt == IDX_W'(TILE_N - 1)) begin
          state <= ST_SEND;
          fillCnt <= '0;
          wordIdx <= '0;
        end else begin
          fillCnt <= fillCnt + 1'b1;
        end
      end
    end else begin
      if (wordIdx == lastWord) begin
        state <= ST_FILL;
        wordIdx <= '0;
      end else begin
        wordIdx <= wordIdx + 1'b1;
      end
    end
  end

  // R1
  emit_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> $past(inValid && inReady));
  // R1
  fill_after_burst_chk: assert property (@(posedge clk) disable iff (rst)
    outLast |=> (inReady && !outValid));
  // R7
  word_step_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outLast) |=> (outValid && wordIdx == $past(wordIdx) + 1'b1));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inReady && !inValid) |=> $stable(fillCnt));
endmodule

// File: rtl/tdc_expand.sv
module tdc_expand
  import tdc_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int TILE_N = 64,
  localparam int PAY_W = SAMPLE_W * TILE_N
) (
  input  tileCode_t        code,
  input  logic             isFloat,
  input  logic [PAY_W-1:0] payload,
  output logic [PAY_W-1:0] tile
);
  localparam logic [SAMPLE_W-1:0] MSB = SAMPLE_W'(1) << (SAMPLE_W - 1);

  always_comb begin
    logic [SAMPLE_W-1:0] anchor, v;
    logic signed [1:0] f2;
    logic signed [2:0] f3;
    logic signed [3:0] f4;
    anchor = payload[SAMPLE_W-1:0];
    tile = '0;
    for (int i = 0; i < TILE_N; i++) begin
      f2 = '0;
      f3 = '0;
      f4 = '0;
      if (i > 0) begin
        f2 = payload[SAMPLE_W + (i - 1) * 2 +: 2];
        f3 = payload[SAMPLE_W + (i - 1) * 3 +: 3];
        f4 = payload[SAMPLE_W + (i - 1) * 4 +: 4];
      end
      case (code)
        CODE_D2: v = anchor + SAMPLE_W'(f2);
        CODE_D3: v = anchor + SAMPLE_W'(f3);
        CODE_D4: v = anchor + SAMPLE_W'(f4);
        default: v = payload[i * SAMPLE_W +: SAMPLE_W];
      endcase
      if (isFloat) v = v[SAMPLE_W-1] ? (v ^ MSB) : ~v;
      tile[i * SAMPLE_W +: SAMPLE_W] = v;
    end
  end
endmodule

// File: rtl/tdc_tile_compress.sv
module tdc_tile_compress
  import tdc_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int TILE_N = 64,
  localparam int IDX_W = $clog2(TILE_N),
  localparam int PAY_W = SAMPLE_W * TILE_N
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  output logic                inReady,
  input  logic [SAMPLE_W-1:0] inData,
  input  logic                inFloat,
  output logic                outValid,
  output logic                outLast,
  output logic [1:0]          outCode,
  output logic [SAMPLE_W-1:0] outWord,
  input  logic [1:0]          expCode,
  input  logic                expFloat,
  input  logic [PAY_W-1:0]    expPayload,
  output logic [PAY_W-1:0]    expTile
);
  dpStrobe_t strobe;
  logic [IDX_W-1:0] wrIdx, wordIdx, lastWord;
  tileCode_t code;

  tdc_control #(.TILE_N(TILE_N)) i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .lastWord(lastWord),
    .inReady(inReady), .outValid(outValid), .outLast(outLast),
    .strobe(strobe), .wrIdx(wrIdx), .wordIdx(wordIdx)
  );

  tdc_datapath #(.SAMPLE_W(SAMPLE_W), .TILE_N(TILE_N)) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrIdx(wrIdx), .wordIdx(wordIdx),
    .inData(inData), .inFloat(inFloat), .code(code), .lastWord(lastWord),
    .outWord(outWord)
  );

  tdc_expand #(.SAMPLE_W(SAMPLE_W), .TILE_N(TILE_N)) i_exp (
    .code(tileCode_t'(expCode)), .isFloat(expFloat), .payload(expPayload),
    .tile(expTile)
  );

  assign outCode = code;
endmodule

// File: tb/test_tdc_tile_compress.sv
module test_tdc_tile_compress;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 9;
  localparam int tKind[NV] = '{0, 1, 2, 3, 4, 5, 5, 7, 6};
  localparam logic [7:0] tBase[NV] = '{8'h37, 8'h80, 8'h10, 8'hF8, 8'h20, 8'h00, 8'h00, 8'h50, 8'h09};
  localparam bit tFlt[NV] = '{0, 0, 0, 0, 0, 1, 0, 1, 0};
  localparam bit tStall[NV] = '{0, 0, 1, 0, 0, 0, 0, 1, 0};
  localparam logic [1:0] tCode[NV] = '{2'b11, 2'b11, 2'b10, 2'b01, 2'b00, 2'b11, 2'b00, 2'b01, 2'b01};
  localparam int tWords[NV] = '{17, 17, 25, 33, 64, 17, 64, 33, 33};

  logic clk = 0, rst = 1, inValid = 0, inFloat = 0, outValid, outLast, inReady, expFloat = 0;
  logic [7:0] inData = 0, outWord;
  logic [1:0] outCode, expCode = 0;
  logic [511:0] expPayload = 0, expTile;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tdc_tile_compress i_tdc_tile_compress (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inFloat(inFloat), .outValid(outValid), .outLast(outLast), .outCode(outCode),
    .outWord(outWord), .expCode(expCode), .expFloat(expFloat),
    .expPayload(expPayload), .expTile(expTile)
  );

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int kind, input logic [7:0] base, input int i);
    int off;
    logic [7:0] pat [4] = '{8'h00, 8'h01, 8'h80, 8'h81};
    if (kind == 5) return pat[i % 4];
    case (kind)
      1: off = (i % 4) - 2;
      2: off = (i % 8) - 4;
      3: off = (i % 16) - 8;
      4: off = (i == 40) ? 8 : 0;
      6: off = -8;
      7: off = 4;
      default: off = 0;
    endcase
    if (i == 0) off = 0;
    return base + 8'(off);
  endfunction

  function automatic logic [7:0] mapB(input logic [7:0] x, input bit flt);
    if (!flt) return x;
    return x[7] ? ~x : {~x[7], x[6:0]};
  endfunction

  task automatic runTile(input int kind, input logic [7:0] base, input bit flt,
                         input bit stall, input logic [1:0] eCode, input int eWords,
                         input string name);
    logic [7:0] smp [64];
    logic [7:0] m [64];
    logic [511:0] model, recv, orig;
    int lo2, lo3, lo4, w, nW;
    bit last, f2, f3, f4, readyBad;
    f2 = 1; f3 = 1; f4 = 1;
    for (int i = 0; i < 64; i++) begin
      smp[i] = gen(kind, base, i);
      m[i] = mapB(smp[i], flt);
      orig[i * 8 +: 8] = smp[i];
    end
    for (int i = 1; i < 64; i++) begin
      int d;
      d = int'($signed(m[i] - m[0]));
      if (d < -2 || d > 1) f2 = 0;
      if (d < -4 || d > 3) f3 = 0;
      if (d < -8 || d > 7) f4 = 0;
    end
    w = f2 ? 2 : f3 ? 3 : f4 ? 4 : 8;
    model = '0;
    if (w == 8) for (int i = 0; i < 64; i++) model[i * 8 +: 8] = m[i];
    else begin
      model[7:0] = m[0];
      for (int i = 1; i < 64; i++) begin
        logic [7:0] d8;
        d8 = m[i] - m[0];
        for (int b = 0; b < w; b++) model[8 + (i - 1) * w + b] = d8[b];
      end
    end
    lo2 = 0; lo3 = 0; lo4 = 0;
    for (int i = 0; i < 64; i++) begin
      if (stall) begin
        @(negedge clk); inValid = 0; inData = 8'hA5;
      end
      @(negedge clk); inValid = 1; inData = smp[i]; inFloat = flt;
    end
    @(negedge clk);
    inValid = 1; inData = 8'h5A;
    // R1: first word in the cycle right after the 64th acceptance
    chk(outValid === 1'b1, {"R1 burst start ", name}, 512'(outValid), 512'(1));
    chk(outCode === eCode, {"R4 R5 code ", name}, 512'(outCode), 512'(eCode));
    recv = '0; nW = 0; last = 0; readyBad = 0;
    while (!last && nW < 70 && outValid === 1'b1) begin
      if (inReady !== 1'b0) readyBad = 1;
      recv[nW * 8 +: 8] = outWord;
      last = outLast;
      nW++;
      if (last) inValid = 0;
      @(negedge clk);
    end
    inValid = 0;
    chk(!readyBad, {"R1 ready low in burst ", name}, 512'(readyBad), 512'(0));
    chk(nW == eWords, {"R7 word count ", name}, 512'(nW), 512'(eWords));
    chk(outValid === 1'b0 && inReady === 1'b1, {"R1 idle after last ", name},
        512'({outValid, inReady}), 512'(2'b01));
    chk(recv === model, {"R3 R6 R10 payload ", name}, recv, model);
    expCode = outCode === 2'bxx ? 2'b00 : eCode;
    expFloat = flt; expPayload = recv;
    #1;
    chk(expTile === orig, {"R8 round trip ", name}, expTile, orig);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R1 watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(inReady === 1'b1 && outValid === 1'b0, "R9 reset state", 512'({inReady, outValid}), 512'(2'b10));
    for (int v = 0; v < NV; v++)
      runTile(tKind[v], tBase[v], tFlt[v], tStall[v], tCode[v], tWords[v], $sformatf("vec%0d", v));
    // R9: partial tile dropped by reset
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); inValid = 1; inData = 8'(i * 37); inFloat = 0;
    end
    @(negedge clk); inValid = 0; rst = 1;
    @(negedge clk); rst = 0;
    chk(inReady === 1'b1 && outValid === 1'b0, "R9 mid-tile reset", 512'({inReady, outValid}), 512'(2'b10));
    runTile(2, 8'h44, 0, 0, 2'b10, 25, "after reset R9");
    // R2 boundary: negative float tile far from positives
    runTile(0, 8'hFF, 1, 1, 2'b11, 17, "float flat R2");
    runTile(7, 8'hFC, 0, 0, 2'b01, 33, "wrap R3");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule